// File: doc/BRIEF.md
# Wave Operand Collector Sequencer

This block sits between a wide vector register file and a narrow SIMD datapath. A wavefront of 64 lanes executes on a 16-lane SIMD, so one fused multiply-add must read three source rows (A, B, C) from the register file, each row holding one 32-bit value for every lane of the wavefront. The sequencer accepts an instruction, reads the three source rows in three consecutive cycles through a single read port, and leaves the port idle in the fourth cycle, which belongs to result writeback elsewhere.

Once a row set is complete, the block re-slices it in time. It presents four 16-lane groups on consecutive cycles, in ascending lane order. Each group carries A, B and C for the same lanes. To the SIMD, every lane sees its own small first-in first-out queue per operand.

There are two collection banks. The rows of one instruction are gathered into one bank while the previous instruction drains from the other. Instructions accepted every four cycles therefore produce an unbroken operand stream. A source that an instruction does not use is not read and is delivered as zero.

Top module: `wave_operand_collector`

## Requirements
- R1: `in_ready` is high whenever the sequencer is idle. After an acceptance (`in_valid` and `in_ready` high at a clock edge, in cycle n) it is low in cycles n+1 to n+3 and high again in cycle n+4.
- R2: For an instruction accepted in cycle n, the read port presents the A address in cycle n+1, the B address in cycle n+2 and the C address in cycle n+3, with `rf_rd_en` high, for each source that is in use.
- R3: In cycle n+4, and whenever no instruction is in flight, `rf_rd_en` is low.
- R4: Read data is taken from `rf_rd_data` exactly one cycle after its address was presented, and never at any other time.
- R5: Operands for an instruction accepted in cycle n appear with `op_valid` high in cycles n+5 to n+8, with `op_group` 0, 1, 2, 3 in that order. Group g carries lanes 16g to 16g+15. Lane i of a row occupies bits [32i+31:32i], and within a group, lane 16g+k is placed in bits [32k+31:32k].
- R6: In each group, `op_a`, `op_b` and `op_c` hold the A, B and C values of the same lanes in the same cycle.
- R7: `in_src_mask` bit 0 enables A, bit 1 enables B and bit 2 enables C. For a cleared bit, no read is issued in that slot and the operand is driven as all zeros in every group.
- R8: Instructions accepted every four cycles keep `op_valid` high without a gap, and their operand streams do not corrupt each other.
- R9: While `rst_n` is low, `in_ready` is high and `op_valid` and `rf_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_addr_a | input | 8 | Row address of source A |
| in_addr_b | input | 8 | Row address of source B |
| in_addr_c | input | 8 | Row address of source C |
| in_src_mask | input | 3 | Source enables: bit 0 A, bit 1 B, bit 2 C |
| rf_rd_en | output | 1 | Register file read request |
| rf_rd_addr | output | 8 | Register file row address |
| rf_rd_data | input | 2048 | Row returned one cycle after the request |
| op_valid | output | 1 | Lane group valid |
| op_group | output | 2 | Index of the lane group being presented |
| op_a | output | 512 | Source A for 16 lanes |
| op_b | output | 512 | Source B for 16 lanes |
| op_c | output | 512 | Source C for 16 lanes |

## Verification
The bench builds the block with its default parameters: 64 lanes, a 16-lane SIMD, 32-bit elements and 256 rows. With these values every drain takes exactly four groups, and the row addresses 0 and 255 and all eight source-mask patterns can be reached. A long run at full acceptance rate exercises the hand-over between the two banks. The idle cycles between instructions exercise the ready timing. The register model in the bench returns a distinct poison row on every cycle without a read, so a capture taken one cycle early or late, or a missing zero for an unused source, shows up in the operand data.

// File: rtl/occ_pkg.sv
package occ_pkg;

  // Position in the four-cycle read cadence; order is behaviour.
  typedef enum logic [1:0] {
    SLOT_A  = 2'd0,
    SLOT_B  = 2'd1,
    SLOT_C  = 2'd2,
    SLOT_WB = 2'd3
  } slot_e;

  localparam int unsigned NUM_SRC = 3;

endpackage

// File: rtl/occ_read_seq.sv
module occ_read_seq
  import occ_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr_a,
  input  logic [ADDR_W-1:0] in_addr_b,
  input  logic [ADDR_W-1:0] in_addr_c,
  input  logic [NUM_SRC-1:0] in_src_mask,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cap_vld,
  output slot_e             cap_slot,
  output logic              cap_use,
  output logic              cap_bank
);

  logic              busy_q, busy_d;
  slot_e             slot_q, slot_d;
  logic [ADDR_W-1:0] addr_a_q, addr_b_q, addr_c_q;
  logic [NUM_SRC-1:0] mask_q;
  logic              bank_q;
  logic              accept;
  logic              slot_live;
  logic              src_used;
  logic              cap_vld_q;
  slot_e             cap_slot_q;
  logic              cap_use_q, cap_bank_q;

  assign in_ready  = !busy_q || (slot_q == SLOT_WB);
  assign accept    = in_valid && in_ready;
  assign slot_live = busy_q && (slot_q != SLOT_WB);

  always_comb begin
    case (slot_q)
      SLOT_A:  src_used = mask_q[0];
      SLOT_B:  src_used = mask_q[1];
      SLOT_C:  src_used = mask_q[2];
      default: src_used = 1'b0;
    endcase
  end

  always_comb begin
    case (slot_q)
      SLOT_B:  rd_addr = addr_b_q;
      SLOT_C:  rd_addr = addr_c_q;
      default: rd_addr = addr_a_q;
    endcase
  end

  assign rd_en = slot_live && src_used;

  // next-state
  always_comb begin
    busy_d = busy_q;
    slot_d = slot_q;
    if (accept) begin
      busy_d = 1'b1;
      slot_d = SLOT_A;
    end else if (busy_q) begin
      if (slot_q == SLOT_WB) busy_d = 1'b0;
      else                   slot_d = slot_e'(slot_q + 2'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= SLOT_WB;
      bank_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      slot_q <= slot_d;
      if (accept) bank_q <= !bank_q;
    end
  end

  // instruction fields: data registers, enable = accept
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_a_q <= in_addr_a;
      addr_b_q <= in_addr_b;
      addr_c_q <= in_addr_c;
      mask_q   <= in_src_mask;
    end
  end

  // capture tag follows the read by one cycle, matching read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_vld_q <= 1'b0;
    else        cap_vld_q <= slot_live;
  end

  always_ff @(posedge clk) begin
    if (slot_live) begin
      cap_slot_q <= slot_q;
      cap_use_q  <= src_used;
      cap_bank_q <= bank_q;
    end
  end

  assign cap_vld  = cap_vld_q;
  assign cap_slot = cap_slot_q;
  assign cap_use  = cap_use_q;
  assign cap_bank = cap_bank_q;

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready) else $error("ready after accept"); // R1
  AST_NO_READ_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !rd_en) else $error("read in writeback slot"); // R3
  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && slot_q == SLOT_A) |=> (busy_q && slot_q == SLOT_B)) else $error("slot order"); // R2
  AST_CAPTURE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (cap_vld && cap_use)) else $error("capture lag"); // R4

endmodule

// File: rtl/occ_capture_buf.sv
module occ_capture_buf
  import occ_pkg::*;
#(
  parameter int unsigned ROW_W = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_vld,
  input  slot_e            cap_slot,
  input  logic             cap_use,
  input  logic             cap_bank,
  input  logic [ROW_W-1:0] rd_data,
  input  logic             view_bank,
  output logic [ROW_W-1:0] row_a,
  output logic [ROW_W-1:0] row_b,
  output logic [ROW_W-1:0] row_c,
  output logic             launch,
  output logic             launch_bank
);

  localparam int unsigned BANKS = 2;

  logic [ROW_W-1:0] buf_a [BANKS];
  logic [ROW_W-1:0] buf_b [BANKS];
  logic [ROW_W-1:0] buf_c [BANKS];
  logic [ROW_W-1:0] wr_row;

  // unused sources land as zero so the SIMD sees a defined value
  assign wr_row = cap_use ? rd_data : '0;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic bank_hit;
    logic we_a, we_b, we_c;
    assign bank_hit = cap_vld && (cap_bank == b[0]);
    assign we_a     = bank_hit && (cap_slot == SLOT_A);
    assign we_b     = bank_hit && (cap_slot == SLOT_B);
    assign we_c     = bank_hit && (cap_slot == SLOT_C);

    always_ff @(posedge clk) begin
      if (we_a) buf_a[b] <= wr_row;
      if (we_b) buf_b[b] <= wr_row;
      if (we_c) buf_c[b] <= wr_row;
    end
  end

  assign row_a = buf_a[view_bank];
  assign row_b = buf_b[view_bank];
  assign row_c = buf_c[view_bank];

  assign launch      = cap_vld && (cap_slot == SLOT_C);
  assign launch_bank = cap_bank;

  AST_CAPTURE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && cap_slot == SLOT_A) |=> (cap_vld && cap_slot == SLOT_B)) else $error("capture order"); // R2
  AST_SAME_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && cap_slot != SLOT_A) |-> cap_bank == $past(cap_bank)) else $error("bank split"); // R6

endmodule

// File: rtl/occ_lane_drain.sv
module occ_lane_drain #(
  parameter int unsigned ROW_W  = 2048,
  parameter int unsigned GRP_W  = 512,
  parameter int unsigned GROUPS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      launch,
  input  logic                      launch_bank,
  input  logic [ROW_W-1:0]          row_a,
  input  logic [ROW_W-1:0]          row_b,
  input  logic [ROW_W-1:0]          row_c,
  output logic                      view_bank,
  output logic                      op_valid,
  output logic [$clog2(GROUPS)-1:0] op_group,
  output logic [GRP_W-1:0]          op_a,
  output logic [GRP_W-1:0]          op_b,
  output logic [GRP_W-1:0]          op_c
);

  localparam int unsigned GIDX_W = $clog2(GROUPS);
  localparam logic [GIDX_W-1:0] LAST_GRP = GIDX_W'(GROUPS - 1);

  logic              act_q, act_d;
  logic [GIDX_W-1:0] grp_q, grp_d;
  logic              bank_q, bank_d;
  logic              at_last;

  assign at_last = (grp_q == LAST_GRP);

  always_comb begin
    act_d  = act_q;
    grp_d  = grp_q;
    bank_d = bank_q;
    if (launch) begin
      act_d  = 1'b1;
      grp_d  = '0;
      bank_d = launch_bank;
    end else if (act_q) begin
      if (at_last) act_d = 1'b0;
      else         grp_d = grp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      grp_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      grp_q  <= grp_d;
      bank_q <= bank_d;
    end
  end

  assign view_bank = bank_q;
  assign op_valid  = act_q;
  assign op_group  = grp_q;
  assign op_a      = row_a[int'(grp_q) * GRP_W +: GRP_W];
  assign op_b      = row_b[int'(grp_q) * GRP_W +: GRP_W];
  assign op_c      = row_c[int'(grp_q) * GRP_W +: GRP_W];

  AST_GROUP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !at_last) |=> (op_valid && op_group == $past(op_group) + 1'b1)) else $error("group step"); // R5
  AST_GROUP_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> (op_group == '0)) else $error("group start"); // R5

endmodule

// File: rtl/wave_operand_collector.sv
module wave_operand_collector
  import occ_pkg::*;
#(
  parameter int unsigned LANES      = 64,
  parameter int unsigned SIMD_LANES = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RF_ROWS    = 256
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    in_valid,
  output logic                                    in_ready,
  input  logic [$clog2(RF_ROWS)-1:0]              in_addr_a,
  input  logic [$clog2(RF_ROWS)-1:0]              in_addr_b,
  input  logic [$clog2(RF_ROWS)-1:0]              in_addr_c,
  input  logic [2:0]                              in_src_mask,
  output logic                                    rf_rd_en,
  output logic [$clog2(RF_ROWS)-1:0]              rf_rd_addr,
  input  logic [LANES*DATA_W-1:0]                 rf_rd_data,
  output logic                                    op_valid,
  output logic [$clog2(LANES/SIMD_LANES)-1:0]     op_group,
  output logic [SIMD_LANES*DATA_W-1:0]            op_a,
  output logic [SIMD_LANES*DATA_W-1:0]            op_b,
  output logic [SIMD_LANES*DATA_W-1:0]            op_c
);

  localparam int unsigned ADDR_W = $clog2(RF_ROWS);
  localparam int unsigned ROW_W  = LANES * DATA_W;
  localparam int unsigned GRP_W  = SIMD_LANES * DATA_W;
  localparam int unsigned GROUPS = LANES / SIMD_LANES;
  localparam int unsigned GIDX_W = $clog2(GROUPS);

  logic             cap_vld, cap_use, cap_bank;
  slot_e            cap_slot;
  logic [ROW_W-1:0] row_a, row_b, row_c;
  logic             launch, launch_bank, view_bank;

  occ_read_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_addr_a   (in_addr_a),
    .in_addr_b   (in_addr_b),
    .in_addr_c   (in_addr_c),
    .in_src_mask (in_src_mask),
    .rd_en       (rf_rd_en),
    .rd_addr     (rf_rd_addr),
    .cap_vld     (cap_vld),
    .cap_slot    (cap_slot),
    .cap_use     (cap_use),
    .cap_bank    (cap_bank)
  );

  occ_capture_buf #(.ROW_W(ROW_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_vld     (cap_vld),
    .cap_slot    (cap_slot),
    .cap_use     (cap_use),
    .cap_bank    (cap_bank),
    .rd_data     (rf_rd_data),
    .view_bank   (view_bank),
    .row_a       (row_a),
    .row_b       (row_b),
    .row_c       (row_c),
    .launch      (launch),
    .launch_bank (launch_bank)
  );

  occ_lane_drain #(.ROW_W(ROW_W), .GRP_W(GRP_W), .GROUPS(GROUPS)) u_drain (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .launch_bank (launch_bank),
    .row_a       (row_a),
    .row_b       (row_b),
    .row_c       (row_c),
    .view_bank   (view_bank),
    .op_valid    (op_valid),
    .op_group    (op_group),
    .op_a        (op_a),
    .op_b        (op_b),
    .op_c        (op_c)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (!op_valid || op_group == GIDX_W'(GROUPS - 1))) else $error("drain overrun"); // R8
  AST_BANK_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && op_valid) |-> (cap_bank != view_bank)) else $error("bank collision"); // R8
  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_group == GIDX_W'(GROUPS - 1) && launch) |=> op_valid) else $error("bubble"); // R8

endmodule

// File: tb/test_wave_operand_collector.sv
`timescale 1ns/1ps
module test_wave_operand_collector;

  localparam int LANES = 64;
  localparam int SIMD  = 16;
  localparam int DW    = 32;
  localparam int ROWS  = 256;
  localparam int ROW_W = LANES * DW;
  localparam int GRP_W = SIMD * DW;
  localparam int MAXC  = 4096;
  localparam int NI    = 300;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready;
  logic [7:0] in_addr_a, in_addr_b, in_addr_c;
  logic [2:0] in_src_mask;
  logic rf_rd_en;
  logic [7:0] rf_rd_addr;
  logic [ROW_W-1:0] rf_rd_data;
  logic op_valid;
  logic [1:0] op_group;
  logic [GRP_W-1:0] op_a, op_b, op_c;

  always #2.5 clk = ~clk;

  wave_operand_collector i_wave_operand_collector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr_a(in_addr_a), .in_addr_b(in_addr_b), .in_addr_c(in_addr_c),
    .in_src_mask(in_src_mask), .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr),
    .rf_rd_data(rf_rd_data), .op_valid(op_valid), .op_group(op_group),
    .op_a(op_a), .op_b(op_b), .op_c(op_c)
  );

  function automatic logic [31:0] word_of(int addr, int lane);
    return (32'(addr) * 32'h9E3779B1) ^ (32'(lane) * 32'h85EBCA77) ^ 32'h1357_2468;
  endfunction

  function automatic logic [ROW_W-1:0] row_of(int addr);
    logic [ROW_W-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*DW +: DW] = word_of(addr, l);
    return r;
  endfunction

  function automatic logic [GRP_W-1:0] grp_of(int addr, bit used, int g);
    logic [GRP_W-1:0] r;
    for (int k = 0; k < SIMD; k++) r[k*DW +: DW] = used ? word_of(addr, g*SIMD + k) : 32'h0;
    return r;
  endfunction

  // register file model: one cycle read latency, poison when not reading
  always @(posedge clk) begin
    if (rf_rd_en) rf_rd_data <= row_of(int'(rf_rd_addr));
    else          rf_rd_data <= {(ROW_W/32){32'hA5C3_5A3C}};
  end

  int cyc;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  int  exp_kind [MAXC];   // 0 none, 1 read, 2 skipped source, 3 writeback slot
  int  exp_addr [MAXC];
  bit  exp_opv  [MAXC];
  int  exp_idx  [MAXC];
  int  exp_grp  [MAXC];
  int  ia [NI], ib [NI], ic [NI];
  logic [2:0] im [NI];
  int  last_acc = -100;
  int  issued = 0;
  bit  pending = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [GRP_W-1:0] act, input logic [GRP_W-1:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, expv);
    end
  endtask

  task automatic record(input int c, input int k);
    int ad [3];
    last_acc = c;
    ad[0] = ia[k]; ad[1] = ib[k]; ad[2] = ic[k];
    for (int s = 0; s < 3; s++) begin
      exp_kind[c+1+s] = im[k][s] ? 1 : 2;
      exp_addr[c+1+s] = ad[s];
    end
    exp_kind[c+4] = 3;
    for (int g = 0; g < 4; g++) begin
      exp_opv[c+5+g] = 1'b1;
      exp_idx[c+5+g] = k;
      exp_grp[c+5+g] = g;
    end
  endtask

  task automatic check_cycle();
    bit rdy_exp;
    bit en_exp;
    int k, g;
    rdy_exp = (cyc >= last_acc + 4);
    chk(in_ready == rdy_exp, "R1", "in_ready", GRP_W'(in_ready), GRP_W'(rdy_exp));
    en_exp = (exp_kind[cyc] == 1);
    case (exp_kind[cyc])
      3:       chk(rf_rd_en == 1'b0, "R3", "rd_en in writeback slot", GRP_W'(rf_rd_en), '0);
      2:       chk(rf_rd_en == 1'b0, "R7", "rd_en for unused source", GRP_W'(rf_rd_en), '0);
      1:       chk(rf_rd_en == 1'b1, "R2", "rd_en for source", GRP_W'(rf_rd_en), GRP_W'(1));
      default: chk(rf_rd_en == 1'b0, "R3", "rd_en while idle", GRP_W'(rf_rd_en), '0);
    endcase
    if (en_exp)
      chk(int'(rf_rd_addr) == exp_addr[cyc], "R2", "rd_addr", GRP_W'(rf_rd_addr), GRP_W'(exp_addr[cyc]));
    chk(op_valid == exp_opv[cyc], "R8", "op_valid", GRP_W'(op_valid), GRP_W'(exp_opv[cyc]));
    if (exp_opv[cyc] && op_valid) begin
      k = exp_idx[cyc];
      g = exp_grp[cyc];
      chk(int'(op_group) == g, "R5", "op_group", GRP_W'(op_group), GRP_W'(g));
      chk(op_a == grp_of(ia[k], im[k][0], g), im[k][0] ? "R4" : "R7", "op_a", op_a, grp_of(ia[k], im[k][0], g));
      chk(op_b == grp_of(ib[k], im[k][1], g), im[k][1] ? "R6" : "R7", "op_b", op_b, grp_of(ib[k], im[k][1], g));
      chk(op_c == grp_of(ic[k], im[k][2], g), im[k][2] ? "R6" : "R7", "op_c", op_c, grp_of(ic[k], im[k][2], g));
    end
  endtask

  task automatic drive();
    if (!pending && issued < NI) begin
      bit present;
      if (issued < 48) present = 1'b1;             // back-to-back phases
      else             present = ($urandom % 3) != 0;
      if (present) begin
        ia[issued] = int'($urandom % ROWS);
        ib[issued] = int'($urandom % ROWS);
        ic[issued] = int'($urandom % ROWS);
        if (issued < 24)      im[issued] = 3'b111;
        else if (issued < 48) im[issued] = 3'(issued % 8);
        else                  im[issued] = 3'($urandom % 8);
        if (issued == 48) begin ia[issued] = 0;   ib[issued] = 255; ic[issued] = 0;   im[issued] = 3'b111; end
        if (issued == 49) begin ia[issued] = 255; ib[issued] = 0;   ic[issued] = 255; im[issued] = 3'b101; end
        pending = 1'b1;
      end
    end
    in_valid = pending;
    if (pending) begin
      in_addr_a   = 8'(ia[issued]);
      in_addr_b   = 8'(ib[issued]);
      in_addr_c   = 8'(ic[issued]);
      in_src_mask = im[issued];
    end else begin
      in_addr_a   = 8'($urandom);
      in_addr_b   = 8'($urandom);
      in_addr_c   = 8'($urandom);
      in_src_mask = 3'($urandom);
    end
    #1;
    if (in_valid && in_ready) begin
      record(cyc, issued);
      issued++;
      pending = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < MAXC; i++) begin
      exp_kind[i] = 0; exp_addr[i] = 0; exp_opv[i] = 1'b0; exp_idx[i] = 0; exp_grp[i] = 0;
    end
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_addr_a = '0; in_addr_b = '0; in_addr_c = '0; in_src_mask = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(in_ready == 1'b1, "R9", "in_ready in reset", GRP_W'(in_ready), GRP_W'(1));
    chk(op_valid == 1'b0, "R9", "op_valid in reset", GRP_W'(op_valid), '0);
    chk(rf_rd_en == 1'b0, "R9", "rf_rd_en in reset", GRP_W'(rf_rd_en), '0);
    rst_n = 1'b1;
    while (cyc < MAXC - 16 && (issued < NI || cyc <= last_acc + 10)) begin
      check_cycle();
      drive();
      @(negedge clk);
    end
    if (issued < NI) chk(1'b0, "R1", "instructions accepted", GRP_W'(issued), GRP_W'(NI));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule